// File: doc/BRIEF.md
# Packed SIMD Integer Adder

This unit adds two 128-bit vectors lane by lane and returns one 128-bit result. The lanes are 8, 16 or 32 bits wide. Five arithmetic modes are available: wrap-around addition, unsigned saturating addition, signed saturating addition, a rounding unsigned average, and carry extraction. Carry extraction stores in each lane the carry that a 32-bit add would otherwise lose. Lane 0 sits in the most significant bits of the vector. No carry ever crosses from one lane into the next.

The operation arrives already decoded, as a mode code and a width code, together with `issue_valid`. One clock later the result shows up with `result_valid`. The result depends only on the operand values presented in the issue cycle, so a destination that aliases either source needs no special handling. The unit holds a sticky saturation flag. Only the two saturating modes can set it, and it stays set until `sat_clear` is pulsed.

Top module: `simd_add_unit`

## Requirements
- R1: Mode 0 (wrap) gives each lane (a + b) mod 2^w for lane width w, with no carry into the neighbouring lane. Width codes are 0 = 8-bit, 1 = 16-bit and 2 = 32-bit lanes. Lane 0 occupies the most significant bits.
- R2: Mode 1 (unsigned saturate) gives each lane a + b. When that sum exceeds 2^w − 1, the lane becomes 2^w − 1.
- R3: Mode 2 (signed saturate) treats the lanes as two's complement. It clamps each sum to the range −2^(w−1) .. 2^(w−1) − 1.
- R4: Mode 3 (average) gives each lane (a + b + 1) >> 1, computed with one extra bit so that the sum never overflows.
- R5: Mode 4 (carry) is defined only for 32-bit lanes. Each lane receives the carry-out of its unsigned 32-bit add, zero-extended to 32 bits.
- R6: The saturation flag becomes set in the cycle after an issued mode 1 or mode 2 operation in which any lane clamps. It is never set by modes 0, 3 or 4. Once set, it stays set until it is cleared.
- R7: Pulsing `sat_clear` clears the flag on the next edge. If a clamping saturating operation is issued in the same cycle, the flag ends up set.
- R8: Modes 5 to 7, width code 3, and mode 4 with 8-bit or 16-bit lanes are undefined. An issued undefined operation yields an all-zero result and leaves the flag unchanged.
- R9: `result_valid` is `issue_valid` delayed by one clock. While nothing is issued, `result` keeps its last value.
- R10: Synchronous active-high reset clears `result_valid`, `result` and the flag.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Operation present this cycle |
| mode | input | 3 | Arithmetic mode code |
| width | input | 2 | Lane width code |
| a | input | 128 | Operand A |
| b | input | 128 | Operand B |
| sat_clear | input | 1 | Clear the sticky saturation flag |
| result_valid | output | 1 | Result register holds a new result |
| result | output | 128 | Registered lane-wise result |
| sat_flag | output | 1 | Sticky saturation status |

## Verification
A flag clear and a new saturation event can fall in the same cycle. The directed part of the bench pulses `sat_clear` together with a clamping saturating add, and also together with a non-saturating add. It expects the flag to be set after the first case and cleared after the second. The random phase drives `sat_clear` independently of the issued operations, so the two also coincide there many times. A behavioural lane model checks the flag and the result on every clock.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

    typedef enum logic [2:0] {
        OP_WRAP  = 3'd0,
        OP_USAT  = 3'd1,
        OP_SSAT  = 3'd2,
        OP_AVG   = 3'd3,
        OP_CARRY = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        LW_BYTE = 2'd0,
        LW_HALF = 2'd1,
        LW_WORD = 2'd2
    } lane_w_e;

    localparam int NUM_LANE_WIDTHS = 3;
    localparam int BASE_LANE_W     = 8;

    function automatic logic op_is_legal(input logic [2:0] m, input logic [1:0] w);
        logic ok;
        ok = (w <= LW_WORD) && (m <= OP_CARRY);
        if (m == OP_CARRY && w != LW_WORD)
            ok = 1'b0;
        return ok;
    endfunction

    function automatic logic op_can_saturate(input logic [2:0] m);
        return (m == OP_USAT) || (m == OP_SSAT);
    endfunction

endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
    import simd_add_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic [2:0]        op,
    input  logic [LANE_W-1:0] x,
    input  logic [LANE_W-1:0] y,
    output logic [LANE_W-1:0] res,
    output logic              clamp
);
    localparam logic [LANE_W-1:0] U_MAX = {LANE_W{1'b1}};
    localparam logic [LANE_W-1:0] S_MAX = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] S_MIN = {1'b1, {(LANE_W-1){1'b0}}};

    logic [LANE_W:0]   sum_ext;
    logic [LANE_W:0]   avg_ext;
    logic [LANE_W-1:0] wrap_v;
    logic              carry_out;
    logic              s_ovf;

    always_comb begin
        sum_ext   = {1'b0, x} + {1'b0, y};
        wrap_v    = sum_ext[LANE_W-1:0];
        carry_out = sum_ext[LANE_W];
        avg_ext   = sum_ext + {{LANE_W{1'b0}}, 1'b1};
        s_ovf     = (x[LANE_W-1] == y[LANE_W-1]) && (wrap_v[LANE_W-1] != x[LANE_W-1]);
    end

    always_comb begin
        res   = '0;
        clamp = 1'b0;
        case (op)
            OP_WRAP: res = wrap_v;
            OP_USAT: begin
                res   = carry_out ? U_MAX : wrap_v;
                clamp = carry_out;
            end
            OP_SSAT: begin
                res   = s_ovf ? (x[LANE_W-1] ? S_MIN : S_MAX) : wrap_v;
                clamp = s_ovf;
            end
            OP_AVG:   res = avg_ext[LANE_W:1];
            OP_CARRY: res = {{(LANE_W-1){1'b0}}, carry_out};
            default:  res = '0;
        endcase
    end
endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank
    import simd_add_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int LANE_W = 8
) (
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] va,
    input  logic [DATA_W-1:0] vb,
    output logic [DATA_W-1:0] vr,
    output logic              any_clamp
);
    localparam int N_LANES = DATA_W / LANE_W;

    logic [N_LANES-1:0] lane_clamp;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        // lane 0 is the most significant slice
        localparam int HI = DATA_W - 1 - i * LANE_W;
        simd_lane_alu #(.LANE_W(LANE_W)) u_lane (
            .op    (op),
            .x     (va[HI -: LANE_W]),
            .y     (vb[HI -: LANE_W]),
            .res   (vr[HI -: LANE_W]),
            .clamp (lane_clamp[i])
        );
    end

    assign any_clamp = |lane_clamp;
endmodule

// File: rtl/simd_add_unit.sv
module simd_add_unit
    import simd_add_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  logic [2:0]        mode,
    input  logic [1:0]        width,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sat_clear,
    output logic              result_valid,
    output logic [DATA_W-1:0] result,
    output logic              sat_flag
);
    logic [DATA_W-1:0] bank_res   [NUM_LANE_WIDTHS];
    logic              bank_clamp [NUM_LANE_WIDTHS];

    for (genvar g = 0; g < NUM_LANE_WIDTHS; g++) begin : g_bank
        simd_lane_bank #(
            .DATA_W (DATA_W),
            .LANE_W (BASE_LANE_W << g)
        ) u_bank (
            .op        (mode),
            .va        (a),
            .vb        (b),
            .vr        (bank_res[g]),
            .any_clamp (bank_clamp[g])
        );
    end

    logic              legal;
    logic [DATA_W-1:0] sel_res;
    logic              sat_event;

    always_comb begin
        legal     = op_is_legal(mode, width);
        sel_res   = '0;
        sat_event = 1'b0;
        if (legal) begin
            for (int g = 0; g < NUM_LANE_WIDTHS; g++) begin
                if (width == 2'(g)) begin
                    sel_res   = bank_res[g];
                    sat_event = op_can_saturate(mode) && bank_clamp[g];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_valid <= 1'b0;
            result       <= '0;
            sat_flag     <= 1'b0;
        end else begin
            result_valid <= issue_valid;
            if (issue_valid)
                result <= sel_res;
            sat_flag <= (sat_flag && !sat_clear) || (issue_valid && sat_event);
        end
    end
endmodule

// File: rtl/simd_add_chk.sv
module simd_add_chk #(
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              issue_valid,
    input logic [2:0]        mode,
    input logic [1:0]        width,
    input logic              sat_clear,
    input logic              result_valid,
    input logic [DATA_W-1:0] result,
    input logic              sat_flag
);
    function automatic logic [DATA_W-1:0] carry_bits();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W / 32; i++)
            m[i * 32] = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] CARRY_MASK = carry_bits();

    logic undefined_op;
    logic sat_op;
    assign undefined_op = (mode > 3'd4) || (width == 2'd3) || (mode == 3'd4 && width != 2'd2);
    assign sat_op       = (mode == 3'd1 || mode == 3'd2) && (width != 2'd3);

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        issue_valid |=> result_valid);
    // R9
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |=> !result_valid);
    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |=> $stable(result));
    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (sat_flag && !sat_clear) |=> sat_flag);
    // R6
    flag_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sat_flag) |-> ($past(issue_valid) && $past(sat_op)));
    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (sat_clear && !(issue_valid && sat_op)) |=> !sat_flag);
    // R8
    undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && undefined_op) |=> (result == '0));
    // R8
    undef_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && undefined_op && !sat_clear) |=> (sat_flag == $past(sat_flag)));
    // R5
    carry_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && mode == 3'd4 && width == 2'd2) |=> ((result & ~CARRY_MASK) == '0));
    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!result_valid && !sat_flag && result == '0));
endmodule

bind simd_add_unit simd_add_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .issue_valid  (issue_valid),
    .mode         (mode),
    .width        (width),
    .sat_clear    (sat_clear),
    .result_valid (result_valid),
    .result       (result),
    .sat_flag     (sat_flag)
);

// File: tb/tb_simd_add_unit.sv
`timescale 1ns/1ps
module tb_simd_add_unit;
    localparam real PERIOD = 20.0;

    logic         clk = 1'b0;
    logic         rst;
    logic         issue_valid;
    logic [2:0]   mode;
    logic [1:0]   width;
    logic [127:0] a, b;
    logic         sat_clear;
    logic         result_valid;
    logic [127:0] result;
    logic         sat_flag;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic         exp_valid;
    logic [127:0] exp_res;
    logic         exp_flag;

    always #(PERIOD / 2) clk = ~clk;

    simd_add_unit dut (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .mode(mode), .width(width),
        .a(a), .b(b), .sat_clear(sat_clear), .result_valid(result_valid),
        .result(result), .sat_flag(sat_flag)
    );

    function automatic void ref_op(input int m, input int w, input logic [127:0] va,
                                   input logic [127:0] vb, output logic [127:0] r, output bit sat);
        int lw, n;
        longint mask, half, ua, ub, sa, sb, v, s;
        logic [127:0] ta, tb;
        r = '0;
        sat = 0;
        if (w > 2 || m > 4 || (m == 4 && w != 2)) return;
        lw = 8 << w;
        n = 128 / lw;
        mask = (64'sd1 <<< lw) - 1;
        half = 64'sd1 <<< (lw - 1);
        for (int i = 0; i < n; i++) begin
            ta = va >> (i * lw);
            tb = vb >> (i * lw);
            ua = longint'({32'd0, ta[31:0]}) & mask;
            ub = longint'({32'd0, tb[31:0]}) & mask;
            sa = (ua >= half) ? ua - (mask + 1) : ua;
            sb = (ub >= half) ? ub - (mask + 1) : ub;
            v = 0;
            case (m)
                0: v = ua + ub;
                1: begin
                    v = ua + ub;
                    if (v > mask) begin v = mask; sat = 1; end
                end
                2: begin
                    s = sa + sb;
                    if (s > half - 1) begin v = half - 1; sat = 1; end
                    else if (s < -half) begin v = -half; sat = 1; end
                    else v = s;
                end
                3: v = (ua + ub + 1) >>> 1;
                default: v = (ua + ub) >>> lw;
            endcase
            r = r | (128'(v & mask) << (i * lw));
        end
    endfunction

    task automatic check_all(input string tag);
        checks++;
        if (result_valid !== exp_valid) begin
            failures++;
            $display("FAIL %s result_valid actual=%0b expected=%0b", tag, result_valid, exp_valid);
        end
        checks++;
        if (result !== exp_res) begin
            failures++;
            $display("FAIL %s result actual=%h expected=%h", tag, result, exp_res);
        end
        checks++;
        if (sat_flag !== exp_flag) begin
            failures++;
            $display("FAIL %s sat_flag actual=%0b expected=%0b", tag, sat_flag, exp_flag);
        end
    endtask

    // drive at negedge, model update after posedge, compare at next negedge
    task automatic step(input bit iv, input int m, input int w, input logic [127:0] va,
                        input logic [127:0] vb, input bit clr, input string tag);
        logic [127:0] r;
        bit sat;
        issue_valid = iv;
        mode = 3'(m);
        width = 2'(w);
        a = va;
        b = vb;
        sat_clear = clr;
        @(posedge clk);
        if (rst) begin
            exp_valid = 0; exp_res = '0; exp_flag = 0;
        end else begin
            ref_op(m, w, va, vb, r, sat);
            exp_valid = iv;
            if (iv) exp_res = r;
            exp_flag = (exp_flag && !clr) || (iv && sat);
        end
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [127:0] ra, rb;
        exp_valid = 0; exp_res = '0; exp_flag = 0;
        rst = 1;
        @(negedge clk);
        step(1, 1, 0, {16{8'hFF}}, {16{8'hFF}}, 0, "R10");
        step(0, 0, 0, '0, '0, 0, "R10");
        rst = 0;
        // R1 wrap in all widths, overflow must not spill into next lane
        step(1, 0, 0, {8'hFF, 8'h01, {14{8'h80}}}, {8'h01, 8'hFF, {14{8'h80}}}, 0, "R1");
        step(1, 0, 1, {8{16'hFFFF}}, {8{16'h0002}}, 0, "R1");
        step(1, 0, 2, {4{32'hFFFF_FFFF}}, {4{32'h0000_0003}}, 0, "R1");
        // R9 hold while idle
        step(0, 0, 0, {16{8'h11}}, {16{8'h22}}, 0, "R9");
        step(0, 0, 0, '0, '0, 0, "R9");
        // R2 unsigned saturation, sets flag R6
        step(1, 1, 0, {8'hF0, 8'h10, {14{8'h01}}}, {8'h20, 8'h20, {14{8'h02}}}, 0, "R2");
        // R6 flag sticky through non-saturating ops
        step(1, 0, 0, {16{8'hFF}}, {16{8'hFF}}, 0, "R6");
        step(1, 3, 1, {8{16'hFFFF}}, {8{16'hFFFF}}, 0, "R6");
        // R7 clear
        step(1, 0, 0, '0, '0, 1, "R7");
        // R6 wrap/average/carry never set flag
        step(1, 0, 2, {4{32'h8000_0000}}, {4{32'h8000_0000}}, 0, "R6");
        // R5 carry
        step(1, 4, 2, {32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0},
             {32'h1, 32'h8000_0000, 32'h8000_0000, 32'h0}, 0, "R5");
        // R4 average with rounding and full precision
        step(1, 3, 0, {8'hFF, 8'h00, 8'h01, {13{8'h7F}}}, {8'hFF, 8'h01, 8'h02, {13{8'h80}}}, 0, "R4");
        step(1, 3, 2, {4{32'hFFFF_FFFF}}, {4{32'hFFFF_FFFE}}, 0, "R4");
        // R3 signed saturation both directions
        step(1, 2, 0, {8'h7F, 8'h80, 8'h40, {13{8'hFF}}}, {8'h01, 8'hFF, 8'h3F, {13{8'h01}}}, 0, "R3");
        step(1, 0, 0, '0, '0, 1, "R7");
        step(1, 2, 1, {8{16'h8000}}, {8{16'h8000}}, 0, "R3");
        // R7 clear together with new clamp: flag stays set
        step(1, 2, 2, {4{32'h7FFF_FFFF}}, {4{32'h1}}, 1, "R7");
        // R8 undefined combos: zero result, flag unchanged
        step(1, 4, 0, {16{8'hFF}}, {16{8'hFF}}, 0, "R8");
        step(1, 1, 3, {16{8'hFF}}, {16{8'hFF}}, 0, "R8");
        step(1, 7, 1, {16{8'hFF}}, {16{8'hFF}}, 0, "R8");
        step(1, 4, 1, {16{8'hFF}}, {16{8'hFF}}, 1, "R8");
        step(1, 1, 3, {16{8'hFF}}, {16{8'hFF}}, 0, "R8");
        // random sweep, including clear coincident with saturation
        for (int k = 0; k < 2000; k++) begin
            ra = {$urandom, $urandom, $urandom, $urandom};
            rb = {$urandom, $urandom, $urandom, $urandom};
            step(($urandom % 4) != 0, $urandom % 8, $urandom % 4, ra, rb,
                 ($urandom % 5) == 0, "R1_R9_mix");
        end
        rst = 1;
        step(0, 0, 0, '0, '0, 0, "R10");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule